// File: doc/BRIEF.md
# ECC Correction Result Applier

This block sits between a symbol-correcting ECC decoder and the local RAM that holds one page (2048 data bytes plus 64 spare bytes). When the decoder signals that its correction results are ready, the block looks at up to four 32-bit result words. Each word names a byte offset in the buffer and an XOR pattern. For every word that is not the "no error" sentinel, the block reads the addressed byte, XORs in the pattern and writes the byte back.

A flag for each slot records which corrections have already been written in the current sector. If the decoder keeps reporting the same results, or reports them again, no byte is corrected twice. At the end of each pass the block pulses a clear request back to the decoder status and then pulses `done`. An uncorrectable-fault status from the decoder stops the work at once and raises `fail`. An offset beyond the buffer is dropped and raises a sticky range-error flag. A `sector_start` pulse returns the block to a clean state for the next sector.

Top module: `ecc_patch_applier`

## Requirements
- R1: A result word carries the byte offset in bits 31:16 and the XOR pattern in bits 7:0. Applying it leaves the RAM byte at that offset equal to its old value XOR the pattern.
- R2: A result word equal to 0x03FF03FF is skipped. It causes no RAM access and leaves every byte unchanged.
- R3: Slots are served in ascending slot order, lowest first. Each correction is a read strobe, then in the next cycle a write strobe to the same address, with the write data computed from the read data returned one cycle after the read strobe. If two slots name the same offset, both patterns take effect.
- R4: Each slot is written at most once per sector. Holding `corr_end` high across several passes, or raising it again, writes nothing more.
- R5: A `sector_start` pulse clears the applied flags, `fail` and `range_err`. A later pass then applies the same words again.
- R6: A word whose offset is 2112 or greater makes no RAM access. It sets `range_err`, which stays high until `sector_start`.
- R7: While `corr_fault` is high, no write is made. It sets `fail`, which stays high until `sector_start`, and the interrupted pass gives no `done` pulse. `corr_fault` wins over `corr_end` when both are high in the idle state.
- R8: A pass ends with `status_clr` high for one cycle, in the cycle the scan finds no slot left. `done` is high for exactly the following cycle.
- R9: After reset, `done`, `fail`, `range_err`, `busy`, `status_clr`, `ram_rd_en` and `ram_wr_en` are all low.
- R10: `busy` is high from the cycle after `corr_end` is accepted until the cycle `status_clr` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sector_start | input | 1 | Pulse that begins a new sector and clears the applied flags, fail and range error |
| corr_end | input | 1 | Decoder status: correction results are ready |
| corr_fault | input | 1 | Decoder status: errors cannot be corrected |
| result_words | input | 128 | Four result words; slot k occupies bits 32k+31:32k |
| status_clr | output | 1 | One-cycle request to clear the decoder's correction-end status |
| done | output | 1 | One-cycle pulse after a pass finishes |
| fail | output | 1 | Sticky uncorrectable-fault flag |
| range_err | output | 1 | Sticky out-of-buffer offset flag |
| busy | output | 1 | A pass is in progress |
| ram_rd_en | output | 1 | Buffer RAM read strobe |
| ram_wr_en | output | 1 | Buffer RAM write strobe |
| ram_addr | output | 12 | Buffer RAM byte address |
| ram_wdata | output | 8 | Buffer RAM write data |
| ram_rdata | input | 8 | Buffer RAM read data, valid one cycle after the read strobe |

## Verification
The bench holds `corr_end` high across three passes. A design that ignored its applied flags would XOR the same bytes again and flip them back. It puts the same offset in two slots, where a write path that used stale data would lose one of the patterns. It also places words at the last valid offset (2111), at 2112 and at 0xFFFF, where an off-by-one range check would either drop a good correction or spill into a truncated address. It raises the fault status both together with `corr_end` and after a pass has started, to catch a write or a `done` pulse that leaks through an abort.

// File: rtl/ecc_patch_pkg.sv
package ecc_patch_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OFS_LSB  = 16;
    localparam int unsigned OFS_W    = 16;
    localparam int unsigned MASK_W   = 8;
    localparam logic [WORD_W-1:0] NO_ERR_WORD = 32'h03FF_03FF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ecc_word_decode.sv
module ecc_word_decode
    import ecc_patch_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 2112,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic [WORD_W-1:0] word,
    output logic              present,
    output logic              in_range,
    output logic [ADDR_W-1:0] addr,
    output logic [MASK_W-1:0] mask
);
    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs      = word[OFS_LSB +: OFS_W];
        present  = (word != NO_ERR_WORD);
        in_range = ({16'd0, ofs} < BUF_BYTES);
        addr     = ofs[ADDR_W-1:0];
        mask     = word[MASK_W-1:0];
    end

endmodule

// File: rtl/ecc_slot_tracker.sv
module ecc_slot_tracker #(
    parameter int unsigned SLOTS  = 4,
    parameter int unsigned SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              set_en,
    input  logic [SLOT_W-1:0] set_idx,
    input  logic [SLOTS-1:0]  cand,
    output logic              pick_any,
    output logic [SLOT_W-1:0] pick_idx
);
    logic [SLOTS-1:0] applied_d, applied_q;
    logic [SLOTS-1:0] pending;

    always_comb begin
        applied_d = applied_q;
        if (clear) begin
            applied_d = '0;
        end else if (set_en) begin
            applied_d[set_idx] = 1'b1;
        end
        pending  = cand & ~applied_q;
        pick_any = |pending;
        pick_idx = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (pending[k]) pick_idx = SLOT_W'(k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) applied_q <= '0;
        else        applied_q <= applied_d;
    end

    // R4: a flag that is set stays set until a sector clear
    assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) |-> ((applied_q & $past(applied_q)) == $past(applied_q)));

    // R4: a slot is never marked a second time
    assert_set_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clear) |-> !applied_q[set_idx]);

endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
    import ecc_patch_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 2112,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic              fault,
    input  logic              pick_any,
    input  logic [SLOT_W-1:0] pick_idx,
    input  logic              pick_in_range,
    input  logic [ADDR_W-1:0] pick_addr,
    input  logic [MASK_W-1:0] pick_mask,
    output logic              set_en,
    output logic [SLOT_W-1:0] set_idx,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              status_clr,
    output logic              done,
    output logic              fail,
    output logic              range_err,
    output logic              busy
);
    typedef struct packed {
        seq_state_e        state;
        logic [SLOT_W-1:0] slot;
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] mask;
        logic              done;
        logic              fail;
        logic              range_err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        set_en     = 1'b0;
        set_idx    = r_q.slot;
        ram_rd_en  = 1'b0;
        ram_wr_en  = 1'b0;
        ram_addr   = r_q.addr;
        ram_wdata  = ram_rdata ^ r_q.mask;
        status_clr = 1'b0;
        if (clear) begin
            r_d.state     = ST_IDLE;
            r_d.fail      = 1'b0;
            r_d.range_err = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (fault)      r_d.fail  = 1'b1;
                    else if (start) r_d.state = ST_SCAN;
                end
                ST_SCAN: begin
                    if (fault) begin
                        r_d.fail  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else if (!pick_any) begin
                        status_clr = 1'b1;
                        r_d.done   = 1'b1;
                        r_d.state  = ST_IDLE;
                    end else if (!pick_in_range) begin
                        set_en        = 1'b1;
                        set_idx       = pick_idx;
                        r_d.range_err = 1'b1;
                    end else begin
                        ram_rd_en = 1'b1;
                        ram_addr  = pick_addr;
                        r_d.addr  = pick_addr;
                        r_d.mask  = pick_mask;
                        r_d.slot  = pick_idx;
                        r_d.state = ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (fault) begin
                        r_d.fail  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        ram_wr_en = 1'b1;
                        set_en    = 1'b1;
                        r_d.state = ST_SCAN;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.slot      <= '0;
            r_q.addr      <= '0;
            r_q.mask      <= '0;
            r_q.done      <= 1'b0;
            r_q.fail      <= 1'b0;
            r_q.range_err <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign range_err = r_q.range_err;
    assign busy      = (r_q.state != ST_IDLE);

    // R3: read and write never share a cycle
    assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd_en && ram_wr_en));

    // R3: every write is preceded by a read in the cycle before
    assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> $past(ram_rd_en));

    // R3: the write goes back to the address just read
    assert_wr_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> (ram_addr == $past(ram_addr)));

    // R6: no RAM access outside the buffer
    assert_addr_in_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en || ram_wr_en) |-> ({20'd0, ram_addr} < BUF_BYTES));

    // R7: a fault status blocks writes in the same cycle and the next
    assert_fault_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !ram_wr_en);
    assert_fault_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n || clear)
        fault |=> !ram_wr_en && !done);

    // R8: the status clear request is followed by exactly one done cycle
    assert_done_after_clr_R8: assert property (@(posedge clk) disable iff (!rst_n || clear)
        status_clr |=> done);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/ecc_patch_applier.sv
module ecc_patch_applier
    import ecc_patch_pkg::*;
#(
    parameter int unsigned SLOTS     = 4,
    parameter int unsigned BUF_BYTES = 2112,
    localparam int unsigned ADDR_W   = $clog2(BUF_BYTES),
    localparam int unsigned SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sector_start,
    input  logic                     corr_end,
    input  logic                     corr_fault,
    input  logic [SLOTS*WORD_W-1:0]  result_words,
    output logic                     status_clr,
    output logic                     done,
    output logic                     fail,
    output logic                     range_err,
    output logic                     busy,
    output logic                     ram_rd_en,
    output logic                     ram_wr_en,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic [7:0]               ram_wdata,
    input  logic [7:0]               ram_rdata
);
    logic [SLOTS-1:0]  slot_present;
    logic [SLOTS-1:0]  slot_in_range;
    logic [ADDR_W-1:0] slot_addr [SLOTS];
    logic [MASK_W-1:0] slot_mask [SLOTS];

    logic              pick_any;
    logic [SLOT_W-1:0] pick_idx;
    logic              set_en;
    logic [SLOT_W-1:0] set_idx;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        ecc_word_decode #(
            .BUF_BYTES (BUF_BYTES),
            .ADDR_W    (ADDR_W)
        ) u_dec (
            .word     (result_words[g*WORD_W +: WORD_W]),
            .present  (slot_present[g]),
            .in_range (slot_in_range[g]),
            .addr     (slot_addr[g]),
            .mask     (slot_mask[g])
        );
    end

    ecc_slot_tracker #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sector_start),
        .set_en   (set_en),
        .set_idx  (set_idx),
        .cand     (slot_present),
        .pick_any (pick_any),
        .pick_idx (pick_idx)
    );

    ecc_rmw_seq #(
        .BUF_BYTES (BUF_BYTES),
        .ADDR_W    (ADDR_W),
        .SLOT_W    (SLOT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (sector_start),
        .start         (corr_end),
        .fault         (corr_fault),
        .pick_any      (pick_any),
        .pick_idx      (pick_idx),
        .pick_in_range (slot_in_range[pick_idx]),
        .pick_addr     (slot_addr[pick_idx]),
        .pick_mask     (slot_mask[pick_idx]),
        .set_en        (set_en),
        .set_idx       (set_idx),
        .ram_rd_en     (ram_rd_en),
        .ram_wr_en     (ram_wr_en),
        .ram_addr      (ram_addr),
        .ram_wdata     (ram_wdata),
        .ram_rdata     (ram_rdata),
        .status_clr    (status_clr),
        .done          (done),
        .fail          (fail),
        .range_err     (range_err),
        .busy          (busy)
    );

    // R10: busy drops only when a pass ends, aborts or is cleared
    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(status_clr) || $past(corr_fault) || $past(sector_start));

endmodule

// File: tb/ecc_patch_applier_test.sv
`timescale 1ns/1ps
module ecc_patch_applier_test;
    localparam int BUF = 2112;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sector_start = 1'b0;
    logic         corr_end = 1'b0;
    logic         corr_fault = 1'b0;
    logic [127:0] result_words = '0;
    logic         status_clr, done, fail, range_err, busy;
    logic         ram_rd_en, ram_wr_en;
    logic [11:0]  ram_addr;
    logic [7:0]   ram_wdata;
    logic [7:0]   ram_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [BUF];
    int          wr_total = 0;
    logic [11:0] wr_log [64];

    always #10 clk = ~clk;

    ecc_patch_applier uut (
        .clk(clk), .rst_n(rst_n), .sector_start(sector_start),
        .corr_end(corr_end), .corr_fault(corr_fault), .result_words(result_words),
        .status_clr(status_clr), .done(done), .fail(fail), .range_err(range_err),
        .busy(busy), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // behavioural buffer RAM, one cycle read latency
    always @(posedge clk) begin
        if (ram_rd_en && ram_addr < BUF) ram_rdata <= mem[ram_addr];
        if (ram_wr_en) begin
            if (ram_addr < BUF) mem[ram_addr] <= ram_wdata;
            wr_log[wr_total % 64] <= ram_addr;
            wr_total <= wr_total + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [15:0] ofs, input logic [7:0] m);
        return {ofs, 8'h00, m};
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < BUF; i++) mem[i] = 8'(i) ^ 8'h5A;
    endtask

    task automatic new_sector();
        @(negedge clk); sector_start = 1'b1;
        @(negedge clk); sector_start = 1'b0;
    endtask

    // raise corr_end and keep it high until npass done pulses were seen
    task automatic run_pass(input int npass, output int seen, output bit busy_seen,
                            output bit order_ok);
        bit prev_clr = 1'b0;
        seen = 0; busy_seen = 1'b0; order_ok = 1'b1;
        @(negedge clk); corr_end = 1'b1;
        for (int c = 0; c < 200 && seen < npass; c++) begin
            @(negedge clk);
            if (busy) busy_seen = 1'b1;
            if (done) begin
                seen++;
                if (!prev_clr) order_ok = 1'b0;
            end
            prev_clr = status_clr;
        end
        corr_end = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!done && !fail && !range_err && !busy && !status_clr && !ram_rd_en && !ram_wr_en,
              "R9 reset outputs", {done, fail, range_err, busy, status_clr}, 0);
    endtask

    task automatic t_basic();
        int seen, w0; bit bs, ok;
        logic [7:0] b5, b2111, b100, bsent;
        new_sector();
        b5 = mem[5]; b2111 = mem[2111]; b100 = mem[100]; bsent = mem[1023];
        result_words = {mk(16'd100, 8'h3C), mk(16'd2111, 8'hFF), 32'h03FF03FF, mk(16'd5, 8'h81)};
        w0 = wr_total;
        run_pass(1, seen, bs, ok);
        check(seen == 1, "R8 one done pulse", seen, 1);
        check(ok, "R8 status_clr precedes done", ok, 1);
        check(bs, "R10 busy during pass", bs, 1);
        check(mem[5] == (b5 ^ 8'h81), "R1 byte 5", mem[5], b5 ^ 8'h81);
        check(mem[2111] == (b2111 ^ 8'hFF), "R1 last byte", mem[2111], b2111 ^ 8'hFF);
        check(mem[100] == (b100 ^ 8'h3C), "R1 byte 100", mem[100], b100 ^ 8'h3C);
        check(mem[1023] == bsent, "R2 sentinel untouched", mem[1023], bsent);
        check(wr_total - w0 == 3, "R2 write count", wr_total - w0, 3);
        check(wr_log[w0 % 64] == 5 && wr_log[(w0 + 1) % 64] == 2111 && wr_log[(w0 + 2) % 64] == 100,
              "R3 ascending slot order", wr_log[(w0 + 1) % 64], 2111);
        check(!busy && !fail && !range_err, "R10 idle after pass", busy, 0);
    endtask

    task automatic t_repeat();
        int seen, w0; bit bs, ok;
        logic [7:0] b5;
        b5 = mem[5]; w0 = wr_total;
        run_pass(3, seen, bs, ok);
        check(seen == 3, "R4 three passes ran", seen, 3);
        check(wr_total == w0, "R4 no rewrite", wr_total - w0, 0);
        check(mem[5] == b5, "R4 byte unchanged", mem[5], b5);
    endtask

    task automatic t_sector();
        int seen, w0; bit bs, ok;
        logic [7:0] b5;
        b5 = mem[5]; w0 = wr_total;
        new_sector();
        run_pass(1, seen, bs, ok);
        check(wr_total - w0 == 3, "R5 reapplied after sector_start", wr_total - w0, 3);
        check(mem[5] == (b5 ^ 8'h81), "R5 byte 5 again", mem[5], b5 ^ 8'h81);
    endtask

    task automatic t_dup();
        int seen, w0; bit bs, ok;
        logic [7:0] b9;
        new_sector();
        b9 = mem[9]; w0 = wr_total;
        result_words = {mk(16'd9, 8'hF0), 32'h03FF03FF, 32'h03FF03FF, mk(16'd9, 8'h0F)};
        run_pass(1, seen, bs, ok);
        check(mem[9] == (b9 ^ 8'hFF), "R3 same offset twice", mem[9], b9 ^ 8'hFF);
        check(wr_total - w0 == 2, "R3 two writes", wr_total - w0, 2);
    endtask

    task automatic t_range();
        int seen, w0; bit bs, ok;
        logic [7:0] b7, b64;
        new_sector();
        check(!range_err, "R6 flag starts low", range_err, 0);
        b7 = mem[7]; b64 = mem[64]; w0 = wr_total;
        result_words = {32'h03FF03FF, mk(16'd7, 8'h44), mk(16'hFFFF, 8'h22), mk(16'd2112, 8'h11)};
        run_pass(1, seen, bs, ok);
        check(range_err, "R6 range_err set", range_err, 1);
        check(wr_total - w0 == 1, "R6 only valid write", wr_total - w0, 1);
        check(mem[7] == (b7 ^ 8'h44), "R6 valid slot applied", mem[7], b7 ^ 8'h44);
        check(mem[64] == b64, "R6 no aliased write", mem[64], b64);
        check(seen == 1, "R6 pass completes", seen, 1);
        repeat (3) @(negedge clk);
        check(range_err, "R6 range_err sticky", range_err, 1);
        new_sector();
        @(negedge clk);
        check(!range_err, "R5 range_err cleared", range_err, 0);
    endtask

    task automatic t_fault();
        int w0, seen;
        new_sector();
        result_words = {32'h03FF03FF, 32'h03FF03FF, mk(16'd20, 8'h01), mk(16'd21, 8'h02)};
        w0 = wr_total; seen = 0;
        @(negedge clk); corr_end = 1'b1; corr_fault = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) seen++;
        end
        check(fail, "R7 fail set", fail, 1);
        check(wr_total == w0, "R7 fault wins, no write", wr_total - w0, 0);
        check(seen == 0, "R7 no done on fault", seen, 0);
        corr_end = 1'b0; corr_fault = 1'b0;
        repeat (3) @(negedge clk);
        check(fail, "R7 fail sticky", fail, 1);
        new_sector();
        @(negedge clk);
        check(!fail, "R5 fail cleared", fail, 0);
        // fault raised after the pass has begun
        w0 = wr_total; seen = 0;
        corr_end = 1'b1;
        @(negedge clk); corr_fault = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) seen++;
        end
        check(wr_total == w0, "R7 mid-pass abort no write", wr_total - w0, 0);
        check(fail && seen == 0, "R7 mid-pass fail, no done", seen, 0);
        corr_end = 1'b0; corr_fault = 1'b0;
        new_sector();
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_repeat();
        t_sector();
        t_dup();
        t_range();
        t_fault();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule